// File: doc/BRIEF.md
# Secure Configuration Register Block

This block is the secure-side register window of a system security controller. It occupies a 4 KB offset space and is reached through a simple 32-bit register bus. That bus carries a select, a write enable, a size code, a 12-bit offset and write data, and it returns read data in the same cycle. The block owns three registers:

- a one-bit security-violation response selector;
- a two-bit configuration for the non-secure-callable region;
- the enable mask for the bus-bridge error interrupt.

The first two are driven out continuously as level signals. The block also returns a fixed set of identification bytes.

Registers for peripheral protection and interrupt status belong to neighbouring blocks. For those offsets this block raises a read or write strobe and returns the neighbour's read data. The neighbour decodes the offset from the shared bus. Every register keeps only its own writable bits. A write smaller than a full word is dropped without any effect. A read smaller than a word returns the addressed byte or halfword of the aligned word. An access to an offset that nothing decodes still completes normally, and a one-cycle error pulse is raised.

Top module: `sec_cfg_regs`

## Requirements
- R1: After reset, `resp_cfg_o` is 0, `callable_cfg_o` is 0, `undef_err_o` is 0, and reads of offsets 0x10, 0x14 and 0x48 return 0.
- R2: A full-word write to offset 0x10 stores only bit 0. That bit drives `resp_cfg_o` from the next clock, and offset 0x10 reads it back with all other bits zero.
- R3: A full-word write to offset 0x14 stores only bits [1:0]. These drive `callable_cfg_o` from the next clock and read back at offset 0x14.
- R4: Offset 0x48 keeps only bits [31:16] of a full-word write, with bits [15:0] reading as zero. Offset 0x40 always reads zero.
- R5: A write whose size code is 0 (byte) or 1 (halfword) changes no register, raises no strobe and raises no error.
- R6: Size code 0 returns byte `bus_addr[1:0]` of the aligned word in bits [7:0]. Size code 1 returns the word shifted right by 8×`bus_addr[1:0]`, masked to 16 bits. Size codes 2 and 3 return the whole aligned word. Lane 0 is the least significant byte.
- R7: Offsets 0xFD0 to 0xFFC each return one byte in bits [7:0], with bits [31:8] zero. In increasing address order the bytes are 04 00 00 00 52 B8 0B 00 0D F0 05 B1.
- R8: Offsets 0x24, 0x34 and 0x44 read as zero and raise no read strobe. A full-word write to 0x24 or 0x34 raises `ext_wr_o`. A full-word write to 0x44 has no effect.
- R9: Writes to offsets 0x40, 0x50 and 0x90, to the identification offsets, and to the neighbour status offsets 0x1C, 0x20 and 0x30 change nothing and raise no write strobe.
- R10: Reads of neighbour offsets (0x1C, 0x20, 0x28, 0x30, 0x38, 0x60–0x6C, 0x70, 0x74, 0x80–0x8C, 0xA0–0xAC, 0xB0, 0xB4, 0xC0–0xCC, 0xD0) raise `ext_rd_o` in the same cycle and return `ext_rdata_i`, lane-selected as in R6. Aligned full-word writes to the writable ones raise `ext_wr_o` in the same cycle.
- R11: An access to any other offset reads zero and writes nothing. The same holds for a full-word write with `bus_addr[1:0]` not zero. Either case sets `undef_err_o` for exactly the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| bus_addr | input | 12 | Byte offset within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| ext_rdata_i | input | 32 | Read data from neighbouring register blocks |
| ext_rd_o | output | 1 | Read strobe for a neighbour-owned offset |
| ext_wr_o | output | 1 | Write strobe for a neighbour-owned offset |
| resp_cfg_o | output | 1 | Violation response selector level |
| callable_cfg_o | output | 2 | Non-secure-callable configuration level |
| undef_err_o | output | 1 | One-cycle pulse after an undefined access |

## Verification
The local registers are written with all ones, all zeros and patterns that mix writable and reserved bits. These patterns separate a correct write mask from one that is too wide or too narrow. Each lane and size combination is read from a register with distinct bytes, so a swapped lane or a wrong shift shows up as a different value. Sub-word and misaligned writes are aimed at registers that hold a known non-zero value, which tells a dropped write apart from a partial one. Reads and writes go to local, neighbour-owned, read-only, write-only and undefined offsets in turn, checking strobe and error routing along with the returned data.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // Writable-bit masks of the locally held registers
    localparam logic [DATA_W-1:0] RESP_MASK = 32'h0000_0001;
    localparam logic [DATA_W-1:0] NSC_MASK  = 32'h0000_0003;
    localparam logic [DATA_W-1:0] BRG_MASK  = 32'hFFFF_0000;

    localparam logic [ADDR_W-1:0] OFF_RESP   = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_NSC    = 12'h014;
    localparam logic [ADDR_W-1:0] OFF_BRG_EN = 12'h048;
    localparam logic [ADDR_W-1:0] OFF_ID_LO  = 12'hFD0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [3:0] {
        RG_RESP,
        RG_NSC,
        RG_BRG_EN,
        RG_ZERO,     // reads zero, writes ignored
        RG_ID,
        RG_EXT_RW,   // neighbour register, readable and writable
        RG_EXT_RO,   // neighbour status, read only
        RG_EXT_WO,   // neighbour clear, write only
        RG_UNDEF
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [1:0] lane;
        logic [3:0] id_idx;
    } dec_t;

    function automatic region_e classify(input logic [ADDR_W-1:0] off);
        region_e r;
        if (off >= OFF_ID_LO) begin
            r = RG_ID;
        end else begin
            case (off)
                OFF_RESP:                        r = RG_RESP;
                OFF_NSC:                         r = RG_NSC;
                OFF_BRG_EN:                      r = RG_BRG_EN;
                12'h040, 12'h044,
                12'h050, 12'h090:                r = RG_ZERO;
                12'h01C, 12'h020, 12'h030:       r = RG_EXT_RO;
                12'h024, 12'h034:                r = RG_EXT_WO;
                12'h028, 12'h038,
                12'h060, 12'h064, 12'h068, 12'h06C,
                12'h070, 12'h074,
                12'h080, 12'h084, 12'h088, 12'h08C,
                12'h0A0, 12'h0A4, 12'h0A8, 12'h0AC,
                12'h0B0, 12'h0B4,
                12'h0C0, 12'h0C4, 12'h0C8, 12'h0CC,
                12'h0D0:                         r = RG_EXT_RW;
                default:                         r = RG_UNDEF;
            endcase
        end
        return r;
    endfunction

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h52;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h0B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sec_cfg_decode.sv
module sec_cfg_decode
    import sec_cfg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    localparam int WORD_LSB = 2;

    logic [AW-1:0] aligned_off;
    logic [AW-1:0] id_rel;

    always_comb begin
        aligned_off = {addr[AW-1:WORD_LSB], {WORD_LSB{1'b0}}};
        id_rel      = aligned_off - OFF_ID_LO;
        dec.region  = classify(aligned_off);
        dec.lane    = addr[WORD_LSB-1:0];
        dec.id_idx  = id_rel[WORD_LSB+3:WORD_LSB];
    end
endmodule

// File: rtl/sec_cfg_lane.sv
module sec_cfg_lane
    import sec_cfg_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] word,
    input  logic [1:0]    size,
    input  logic [1:0]    lane,
    output logic [DW-1:0] data
);
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    logic [DW-1:0] shifted;

    always_comb begin
        shifted = word >> (BYTE_W * lane);
        if (size[1]) begin
            data = word;
        end else if (size[0]) begin
            data = {{(DW-HALF_W){1'b0}}, shifted[HALF_W-1:0]};
        end else begin
            data = {{(DW-BYTE_W){1'b0}}, shifted[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/sec_cfg_store.sv
module sec_cfg_store
    import sec_cfg_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  region_e       region,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] resp_word,
    output logic [DW-1:0] nsc_word,
    output logic [DW-1:0] brg_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_word <= '0;
            nsc_word  <= '0;
            brg_word  <= '0;
        end else if (wr_en) begin
            case (region)
                RG_RESP:   resp_word <= wdata & RESP_MASK;
                RG_NSC:    nsc_word  <= wdata & NSC_MASK;
                RG_BRG_EN: brg_word  <= wdata & BRG_MASK;
                default: ;
            endcase
        end
    end

    // R2: selector bit moves only on a write that targets it
    p_resp_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && region == RG_RESP) |=> $stable(resp_word));

    // R3: callable configuration moves only on a write that targets it
    p_nsc_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && region == RG_NSC) |=> $stable(nsc_word));

    // R4: bridge enable moves only on its own write
    p_brg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && region == RG_BRG_EN) |=> $stable(brg_word));
endmodule

// File: rtl/sec_cfg_regs.sv
module sec_cfg_regs
    import sec_cfg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] ext_rdata_i,
    output logic          ext_rd_o,
    output logic          ext_wr_o,
    output logic          resp_cfg_o,
    output logic [1:0]    callable_cfg_o,
    output logic          undef_err_o
);
    dec_t          dec;
    logic          full_word;
    logic          misaligned_wr;
    logic          wr_ok;
    logic          rd_ok;
    logic          undef_hit;
    logic          err_q;
    logic [DW-1:0] resp_word;
    logic [DW-1:0] nsc_word;
    logic [DW-1:0] brg_word;
    logic [DW-1:0] rd_word;

    sec_cfg_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    always_comb begin
        full_word     = bus_size[1];
        misaligned_wr = bus_we && full_word && (dec.lane != 2'd0);
        wr_ok         = bus_sel && bus_we && full_word && !misaligned_wr;
        rd_ok         = bus_sel && !bus_we;
        undef_hit     = bus_sel && (dec.region == RG_UNDEF || misaligned_wr);
        ext_rd_o      = rd_ok && (dec.region == RG_EXT_RW || dec.region == RG_EXT_RO);
        ext_wr_o      = wr_ok && (dec.region == RG_EXT_RW || dec.region == RG_EXT_WO);
    end

    sec_cfg_store #(.DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_ok),
        .region    (dec.region),
        .wdata     (bus_wdata),
        .resp_word (resp_word),
        .nsc_word  (nsc_word),
        .brg_word  (brg_word)
    );

    always_comb begin
        case (dec.region)
            RG_RESP:   rd_word = resp_word;
            RG_NSC:    rd_word = nsc_word;
            RG_BRG_EN: rd_word = brg_word;
            RG_ID:     rd_word = {{(DW-8){1'b0}}, id_byte(dec.id_idx)};
            RG_EXT_RW,
            RG_EXT_RO: rd_word = ext_rdata_i;
            default:   rd_word = '0;
        endcase
    end

    sec_cfg_lane #(.DW(DW)) u_lane (
        .word (rd_word),
        .size (bus_size),
        .lane (dec.lane),
        .data (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= undef_hit;
        end
    end

    assign resp_cfg_o     = resp_word[0];
    assign callable_cfg_o = nsc_word[1:0];
    assign undef_err_o    = err_q;

    // R4: low half of the bridge enable never reads back as set
    p_brg_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && dec.region == RG_BRG_EN && full_word) |-> (bus_rdata[15:0] == 16'h0));

    // R10: neighbour write strobe only for aligned full-word accesses
    p_ext_wr_word_r10: assert property (@(posedge clk) disable iff (rst)
        ext_wr_o |-> (bus_size[1] && bus_addr[1:0] == 2'd0 && bus_we));

    // R11: undefined reads return zero
    p_undef_rd_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_ok && dec.region == RG_UNDEF) |-> (bus_rdata == '0));

    // R11: error pulse traces back to an access in the previous cycle
    p_err_source_r11: assert property (@(posedge clk) disable iff (rst)
        undef_err_o |-> $past(bus_sel));

    // R5: a sub-word write never strobes a neighbour
    p_subword_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && !bus_size[1]) |-> !ext_wr_o);
endmodule

// File: tb/sec_cfg_regs_tb.sv
module sec_cfg_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ext_rdata_i = 32'h1234_5678;
    logic        ext_rd_o;
    logic        ext_wr_o;
    logic        resp_cfg_o;
    logic [1:0]  callable_cfg_o;
    logic        undef_err_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] rd_v;
    logic        strb_rd, strb_wr, err_v;

    always #10 clk = ~clk;

    sec_cfg_regs u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_rdata_i(ext_rdata_i), .ext_rd_o(ext_rd_o),
        .ext_wr_o(ext_wr_o), .resp_cfg_o(resp_cfg_o),
        .callable_cfg_o(callable_cfg_o), .undef_err_o(undef_err_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive after a falling edge, sample combinational results
    // mid-cycle, then sample the registered error after the rising edge.
    task automatic access(input logic we, input logic [1:0] sz,
                          input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = d;
        #5;
        rd_v = bus_rdata; strb_rd = ext_rd_o; strb_wr = ext_wr_o;
        @(negedge clk);
        err_v = undef_err_o;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 resp", {31'b0, resp_cfg_o}, 0);
        check("R1 nsc", {30'b0, callable_cfg_o}, 0);
        check("R1 err", {31'b0, undef_err_o}, 0);
        access(0, 2, 12'h010, 0); check("R1 rd 0x10", rd_v, 0);
        access(0, 2, 12'h014, 0); check("R1 rd 0x14", rd_v, 0);
        access(0, 2, 12'h048, 0); check("R1 rd 0x48", rd_v, 0);
    endtask

    task automatic t_resp();
        access(1, 2, 12'h010, 32'hFFFF_FFFF);
        check("R2 out set", {31'b0, resp_cfg_o}, 1);
        access(0, 2, 12'h010, 0); check("R2 readback", rd_v, 1);
        access(1, 2, 12'h010, 32'hFFFF_FFFE);
        check("R2 masked clear", {31'b0, resp_cfg_o}, 0);
    endtask

    task automatic t_nsc();
        access(1, 2, 12'h014, 32'hFFFF_FFFF);
        check("R3 out all", {30'b0, callable_cfg_o}, 3);
        access(0, 2, 12'h014, 0); check("R3 readback", rd_v, 3);
        access(1, 2, 12'h014, 32'h8000_0002);
        check("R3 out 2", {30'b0, callable_cfg_o}, 2);
    endtask

    task automatic t_bridge();
        access(1, 2, 12'h048, 32'hDEAD_BEEF);
        access(0, 2, 12'h048, 0); check("R4 enable mask", rd_v, 32'hDEAD_0000);
        access(1, 2, 12'h040, 32'hFFFF_FFFF);
        access(0, 2, 12'h040, 0); check("R4 status zero", rd_v, 0);
    endtask

    task automatic t_subword_write();
        access(1, 0, 12'h010, 32'hFFFF_FFFF);
        check("R5 byte write resp", {31'b0, resp_cfg_o}, 0);
        check("R5 byte write err", {31'b0, err_v}, 0);
        access(1, 1, 12'h014, 32'h0000_0001);
        check("R5 half write nsc", {30'b0, callable_cfg_o}, 2);
        access(1, 1, 12'h070, 32'h0);
        check("R5 half write strobe", {31'b0, strb_wr}, 0);
    endtask

    task automatic t_lanes();
        access(0, 0, 12'h04B, 0); check("R6 byte lane3", rd_v, 32'hDE);
        access(0, 0, 12'h04A, 0); check("R6 byte lane2", rd_v, 32'hAD);
        access(0, 1, 12'h04A, 0); check("R6 half lane2", rd_v, 32'hDEAD);
        access(0, 1, 12'h049, 0); check("R6 half lane1", rd_v, 32'hAD00);
        access(0, 0, 12'h048, 0); check("R6 byte lane0", rd_v, 0);
        access(0, 3, 12'h04A, 0); check("R6 word misaligned", rd_v, 32'hDEAD_0000);
    endtask

    task automatic t_id();
        logic [7:0] exp_id [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h52, 8'hB8,
                                    8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 12; i++) begin
            access(0, 2, 12'hFD0 + 12'(4 * i), 0);
            check("R7 id word", rd_v, {24'b0, exp_id[i]});
        end
    endtask

    task automatic t_clear_regs();
        access(0, 2, 12'h024, 0); check("R8 rd 0x24", rd_v, 0);
        check("R8 no rd strobe", {31'b0, strb_rd}, 0);
        access(0, 2, 12'h034, 0); check("R8 rd 0x34", rd_v, 0);
        access(0, 2, 12'h044, 0); check("R8 rd 0x44", rd_v, 0);
        access(1, 2, 12'h024, 32'h1); check("R8 wr strobe 0x24", {31'b0, strb_wr}, 1);
        access(1, 2, 12'h044, 32'h1); check("R8 wr 0x44 strobe", {31'b0, strb_wr}, 0);
        check("R8 wr 0x44 err", {31'b0, err_v}, 0);
    endtask

    task automatic t_readonly();
        access(1, 2, 12'h050, 32'hFFFF_FFFF);
        access(0, 2, 12'h050, 0); check("R9 0x50 zero", rd_v, 0);
        access(1, 2, 12'h090, 32'hFFFF_FFFF);
        access(0, 2, 12'h090, 0); check("R9 0x90 zero", rd_v, 0);
        access(1, 2, 12'hFD0, 32'hFFFF_FFFF);
        access(0, 2, 12'hFD0, 0); check("R9 id kept", rd_v, 32'h04);
        access(1, 2, 12'h01C, 32'hFFFF_FFFF);
        check("R9 status no strobe", {31'b0, strb_wr}, 0);
        check("R9 nsc kept", {30'b0, callable_cfg_o}, 2);
    endtask

    task automatic t_neighbour();
        access(0, 2, 12'h070, 0); check("R10 ext data", rd_v, 32'h1234_5678);
        check("R10 rd strobe", {31'b0, strb_rd}, 1);
        access(0, 0, 12'h0D1, 0); check("R10 ext byte", rd_v, 32'h56);
        access(0, 2, 12'h01C, 0); check("R10 status rd strobe", {31'b0, strb_rd}, 1);
        access(1, 2, 12'h0B4, 32'h5); check("R10 wr strobe", {31'b0, strb_wr}, 1);
        check("R10 wr no rd strobe", {31'b0, strb_rd}, 0);
    endtask

    task automatic t_undefined();
        access(0, 2, 12'h100, 0); check("R11 undef rd zero", rd_v, 0);
        check("R11 err pulse", {31'b0, err_v}, 1);
        @(negedge clk);
        check("R11 err one cycle", {31'b0, undef_err_o}, 0);
        access(1, 2, 12'h015, 32'h1);
        check("R11 misaligned err", {31'b0, err_v}, 1);
        check("R11 misaligned nsc kept", {30'b0, callable_cfg_o}, 2);
        access(1, 2, 12'h200, 32'hFFFF_FFFF);
        check("R11 undef wr err", {31'b0, err_v}, 1);
        access(0, 2, 12'h014, 0); check("R11 nsc readback", rd_v, 2);
        check("R11 defined no err", {31'b0, err_v}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_resp();
        t_nsc();
        t_bridge();
        t_subword_write();
        t_lanes();
        t_id();
        t_clear_regs();
        t_readonly();
        t_neighbour();
        t_undefined();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule